// File: doc/BRIEF.md
# Host Byte Handoff Port

This block passes bytes from a free-running upstream packer to a host over a parallel data bus. The packer cannot be paused: it emits one-cycle valid strobes, each with a byte. The block hands each byte to the host with a four-phase ready/acknowledge exchange. It puts the byte on the bus and raises ready. The host reads the bus and raises its acknowledge line. The block then lowers ready. The host lowers acknowledge once it sees ready low.

The acknowledge line comes from another clock domain, so it passes through a synchronizer chain before the control logic uses it. The bus holds the last accepted byte until the next byte is accepted. This gives the host a whole byte time to read it. A byte that arrives before the previous exchange has fully closed is dropped, and a sticky overrun flag records the loss. The bit source is never stalled.

Top module: `host_byte_port`

## Requirements
- R1: While rst_ni is low, host_rdy_o is 0, host_data_o is 0 and overrun_o is 0.
- R2: A valid strobe that is sampled while the port is idle (ready low and the synchronized acknowledge low) puts byte_i on host_data_o and sets host_rdy_o to 1, both visible right after that same rising edge.
- R3: host_data_o changes only on the edge where host_rdy_o rises. It holds its value while ready is high, through the fall of ready, and until the next byte is accepted.
- R4: With the default two-stage synchronizer, host_rdy_o falls on the third rising edge after host_ack_i goes high, and not earlier.
- R5: After ready falls, a new byte is accepted only once the synchronized acknowledge has returned low. A strobe sampled on the third edge after host_ack_i falls is still dropped. A strobe on the fourth edge is accepted.
- R6: A valid strobe sampled while an exchange is open (ready high, or waiting for acknowledge to clear) is dropped. It sets overrun_o to 1 on that edge and leaves host_data_o and host_rdy_o unchanged.
- R7: Once overrun_o is 1, it stays 1 through later exchanges and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Byte from the upstream packer |
| byte_valid_i | input | 1 | One-cycle strobe qualifying byte_i |
| host_ack_i | input | 1 | Host acknowledge, asynchronous |
| host_data_o | output | 8 | Parallel data bus to the host |
| host_rdy_o | output | 1 | Byte-ready line to the host |
| overrun_o | output | 1 | Sticky flag set when a byte is dropped |

## Verification
The bench checks the exact edge on which ready falls after acknowledge rises. A design that skipped a synchronizer stage would lower ready one cycle early, and one that added a stage would lower it one cycle late. The bench also sends a strobe on the last edge before the synchronized acknowledge clears, and another on the first edge after. A design that reopened too early would accept the first of these, and one that reopened too late would drop the second. Strobes that arrive during an open exchange must leave the bus unchanged and set the flag. A design that reloaded the bus while ready was high, or that cleared the flag after a clean exchange, would show a wrong bus value or a flag that is low.

// File: rtl/host_byte_port_pkg.sv
package host_byte_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_DRAIN = 2'd2
  } port_state_e;
endpackage

// File: rtl/hbp_ack_sync.sv
module hbp_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hbp_ctrl.sv
module hbp_ctrl
  import host_byte_port_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic ack_sync_i,
  output logic accept_o,
  output logic drop_o,
  output logic rdy_o
);
  port_state_e state_q, state_d;

  assign accept_o = valid_i && (state_q == ST_IDLE);
  assign drop_o   = valid_i && (state_q != ST_IDLE);
  assign rdy_o    = (state_q == ST_READY);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (valid_i)     state_d = ST_READY;
      ST_READY: if (ack_sync_i)  state_d = ST_DRAIN;
      ST_DRAIN: if (!ack_sync_i) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  AST_RDY_RISE_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(valid_i)); // R2
  AST_RDY_FALL_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(ack_sync_i)); // R4
  AST_NO_REOPEN_UNDER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> !$past(ack_sync_i)); // R5
endmodule

// File: rtl/hbp_data_hold.sv
module hbp_data_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (load_i) data_o <= data_i;
  end
endmodule

// File: rtl/hbp_sticky.sv
module hbp_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end

  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |=> flag_o); // R7
endmodule

// File: rtl/host_byte_port.sv
module host_byte_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              byte_valid_i,
  input  logic              host_ack_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_rdy_o,
  output logic              overrun_o
);
  logic ack_sync;
  logic accept;
  logic drop;

  hbp_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (host_ack_i),
    .sync_o  (ack_sync)
  );

  hbp_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (byte_valid_i),
    .ack_sync_i (ack_sync),
    .accept_o   (accept),
    .drop_o     (drop),
    .rdy_o      (host_rdy_o)
  );

  hbp_data_hold #(.WIDTH(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .data_i (byte_i),
    .data_o (host_data_o)
  );

  hbp_sticky u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (drop),
    .flag_o (overrun_o)
  );

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rdy_o |=> $stable(host_data_o)); // R3
  AST_DROP_KEEPS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && host_rdy_o) |=> (host_rdy_o && overrun_o && $stable(host_data_o))); // R6
endmodule

// File: tb/host_byte_port_tb.sv
module host_byte_port_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       byte_valid_i = 1'b0;
  logic       host_ack_i = 1'b0;
  logic [7:0] host_data_o;
  logic       host_rdy_o;
  logic       overrun_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_data;
  logic       exp_ovr;

  always #4 clk_i = ~clk_i;

  host_byte_port u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_i       (byte_i),
    .byte_valid_i (byte_valid_i),
    .host_ack_i   (host_ack_i),
    .host_data_o  (host_data_o),
    .host_rdy_o   (host_rdy_o),
    .overrun_o    (overrun_o)
  );

  function automatic logic ovr_after(input logic ovr, input logic busy, input logic valid);
    return ovr | (busy & valid);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_state(input string req, input logic rdy);
    chk(host_rdy_o === rdy, req, {31'd0, host_rdy_o}, {31'd0, rdy});
    chk(host_data_o === exp_data, req, {24'd0, host_data_o}, {24'd0, exp_data});
    chk(overrun_o === exp_ovr, req, {31'd0, overrun_o}, {31'd0, exp_ovr});
  endtask

  // called at a negedge; strobe sampled at the next posedge
  task automatic send_byte(input logic [7:0] b, input logic busy);
    byte_i = b;
    byte_valid_i = 1'b1;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
    exp_ovr = ovr_after(exp_ovr, busy, 1'b1);
    if (!busy) exp_data = b;
  endtask

  // host side: waits pre cycles, raises ack, checks the drop edge, releases ack
  task automatic host_take(input int pre);
    for (int i = 0; i < pre; i++) begin
      @(negedge clk_i);
      chk_state("R3", 1'b1);
    end
    host_ack_i = 1'b1;
    @(negedge clk_i);
    chk_state("R4", 1'b1);
    @(negedge clk_i);
    chk_state("R4", 1'b1);
    @(negedge clk_i);
    chk_state("R4", 1'b0);
    host_ack_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    exp_data = 8'h00;
    exp_ovr = 1'b0;
    @(negedge clk_i);
    chk_state("R1", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'h0BAD_5EED));
    exp_data = 8'h00;
    exp_ovr = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk_state("R1", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed: basic exchange
    send_byte(8'hA5, 1'b0);
    chk_state("R2", 1'b1);
    host_take(2);
    @(negedge clk_i);
    chk_state("R3", 1'b0);
    @(negedge clk_i);
    // strobe sampled on third edge after ack fell: dropped
    send_byte(8'h3C, 1'b1);
    chk_state("R5", 1'b0);
    // fourth edge: accepted
    send_byte(8'hC3, 1'b0);
    chk_state("R5", 1'b1);
    // intruder while ready high
    send_byte(8'h77, 1'b1);
    chk_state("R6", 1'b1);
    host_take(1);
    repeat (3) @(negedge clk_i);
    send_byte(8'h12, 1'b0);
    chk_state("R7", 1'b1);
    host_take(0);
    repeat (3) @(negedge clk_i);
    chk_state("R7", 1'b0);
    do_reset();

    // random exchanges with occasional intruders
    for (int n = 0; n < 300; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      send_byte(b, 1'b0);
      chk_state("R2", 1'b1);
      if ($urandom_range(0, 3) == 0) begin
        send_byte(8'($urandom), 1'b1);
        chk_state("R6", 1'b1);
      end
      host_take(int'($urandom_range(0, 4)));
      if ($urandom_range(0, 5) == 0) begin
        @(negedge clk_i);
        send_byte(8'($urandom), 1'b1);
        chk_state("R5", 1'b0);
        @(negedge clk_i);
      end else begin
        repeat (3 + $urandom_range(0, 3)) @(negedge clk_i);
        chk_state("R3", 1'b0);
      end
      if (n == 150) do_reset();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule